// File: doc/BRIEF.md
# Edge-Selectable Interrupt Vector Controller

This block gathers interrupt requests from sixteen general-purpose input lines and turns them into a single request to the processor, together with a vector that names the most urgent pending line. Every line passes through a two-flop synchronizer. A per-line mode bit then chooses what the line detects: falling transitions only, or transitions in either direction. Each detected edge sets a sticky pending bit. Software clears a pending bit by writing a one to it. A mask register decides which pending bits may raise the request and take part in the priority choice.

The vector register places a code in its top byte. The code is a multiple of four and is zero when no source is selected. A byte read of the top byte can therefore be added directly to the base of a table of 4-byte jump entries. A halfword read of the top half returns the same code times 256, which indexes a table whose entries are 0x400 bytes apart. Register accesses take several cycles. Each read returns a snapshot taken in the access's first cycle, so the vector cannot shift under a read that is in progress.

Top module: `eivc_top`

## Requirements
- R1: After reset the mode, mask and pending registers read 0, the vector reads 0 and `irq_o` is low.
- R2: A line whose mode bit (mode register, word 0, bit n for line n) is 0 sets its pending bit (pending register, word 2, bit n) on a high-to-low transition only. A low-to-high transition leaves it clear.
- R3: A line whose mode bit is 1 sets its pending bit on any transition of the pin.
- R4: Writing the pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: If an edge on a line is detected in the same cycle that a write-one-to-clear of that line's pending bit takes effect, the bit stays set.
- R6: A pending bit whose mask bit (mask register, word 1, bit n; 1 = enabled) is 0 neither raises `irq_o` nor appears in the vector.
- R7: Among unmasked pending lines, the lowest-numbered line wins: line 0 is first and line 15 is last.
- R8: The vector register (word 3) holds (n+1)*4 in bits 31:24 for winning line n and zeros in bits 23:0. Bits 31:16 therefore read (n+1)*1024. With no unmasked pending line the whole register reads 0.
- R9: Read data is captured in the first cycle of an access and held constant until the acknowledge. A source that becomes pending during the access does not change the returned value.
- R10: `bus_ack` rises WAIT_CYC+1 clock edges after `bus_sel` is first seen high, lasts exactly one cycle, and writes take effect on the edge where it is high.
- R11: `irq_o` is high exactly when the vector register's code is non-zero, that is, when at least one unmasked pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 16 | Asynchronous external interrupt lines |
| bus_sel | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select: 0 mode, 1 mask, 2 pending, 3 vector |
| bus_wdata | input | 32 | Write data (low 16 bits used) |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle access completion |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that a bus master holds `bus_sel`, `bus_we`, `bus_addr` and `bus_wdata` steady from the start of an access until the acknowledge edge, and drops `bus_sel` for at least one cycle between accesses. They also assume that the pins idle high out of reset. The stimulus drives every bus signal only from one transfer task that follows this protocol, and it starts with all pins high. Pin changes are placed at falling clock edges, at times computed so that they either settle well before a check or land on the exact edge that a given corner case needs.

// File: rtl/eivc_pkg.sv
// Package: shared constants and types for the edge-selectable interrupt
// vector controller. Assumes a 2-bit word address space on the register bus.
package eivc_pkg;

    // Word addresses of the register bus; the bench depends on these values.
    typedef enum logic [1:0] {
        RSEL_MODE = 2'd0,
        RSEL_MASK = 2'd1,
        RSEL_PEND = 2'd2,
        RSEL_VEC  = 2'd3
    } rsel_e;

    // Width of the vector code field sitting in the top byte.
    localparam int unsigned CODE_W = 8;

endpackage

// File: rtl/eivc_edge_bank.sv
// Module: per-line synchronizer and edge detector.
// Each line gets a two-flop synchronizer plus a history flop. The mode bit
// picks falling-only (0) or any-change (1) detection. Assumes the pins idle
// high, so the flops reset to 1 and reset release creates no edge.
module eivc_edge_bank #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    input  logic [LINES-1:0] mode_i,
    output logic [LINES-1:0] edge_o
);

    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] hist_q;

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        // Synchronize the pin and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[gi] <= 1'b1;
                sync_q[gi] <= 1'b1;
                hist_q[gi] <= 1'b1;
            end else begin
                meta_q[gi] <= pin_i[gi];
                sync_q[gi] <= meta_q[gi];
                hist_q[gi] <= sync_q[gi];
            end
        end

        // Select falling-only or any-change detection for this line.
        always_comb begin
            if (mode_i[gi]) begin
                edge_o[gi] = hist_q[gi] ^ sync_q[gi];
            end else begin
                edge_o[gi] = hist_q[gi] & ~sync_q[gi];
            end
        end
    end

    // R2: a line in falling-only mode never flags an edge while it sits high.
    p_fall_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o & ~mode_i & sync_q) == '0);

    // R3: any flagged edge implies the synchronized level just changed.
    p_edge_is_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o & ~(hist_q ^ sync_q)) == '0);

endmodule

// File: rtl/eivc_pend_bank.sv
// Module: sticky pending latches with write-one-to-clear.
// When a clear and a new edge hit the same bit in one cycle, the set wins,
// so no edge is lost. Assumes clr_i is a one-cycle strobe per write.
module eivc_pend_bank #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] edge_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] pend_o
);

    logic [LINES-1:0] pend_q;

    // Update pending bits: clear the requested bits, then apply new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | edge_i;
        end
    end

    assign pend_o = pend_q;

    // R5: every detected edge is visible as pending on the next cycle.
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(edge_i)) == $past(edge_i)));

    // R4: a cleared bit with no new edge reads zero on the next cycle.
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(clr_i & ~edge_i)) == '0));

    // R4: bits neither cleared nor hit by an edge keep their value.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(clr_i | edge_i)) == '0));

endmodule

// File: rtl/eivc_prio_vec.sv
// Module: masked priority selection and vector formatting.
// The lowest-numbered unmasked pending line wins. Its code (n+1)*4 goes into
// the top byte of a DATA_W-bit word, and 0 is reserved for "no source".
// Assumes LINES*4+4 fits in the code byte.
module eivc_prio_vec
    import eivc_pkg::*;
#(
    parameter int unsigned LINES  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pend_i,
    input  logic [LINES-1:0]  mask_i,
    output logic [DATA_W-1:0] vector_o,
    output logic              any_o
);

    localparam int unsigned LOW_W = DATA_W - CODE_W;

    logic [LINES-1:0]  hit;
    logic [LINES-1:0]  grant;
    logic [CODE_W-1:0] code;

    assign hit   = pend_i & mask_i;
    // Isolate the lowest set bit of the unmasked pending lines.
    assign grant = hit & (~hit + 1'b1);

    // Turn the one-hot grant into the scaled vector code.
    always_comb begin
        code = '0;
        for (int i = 0; i < LINES; i++) begin
            if (grant[i]) begin
                code = CODE_W'((i + 1) * 4);
            end
        end
    end

    assign vector_o = {code, {LOW_W{1'b0}}};
    assign any_o    = |hit;

    // R7: at most one line is granted at any time.
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: a granted line is always unmasked and pending.
    p_grant_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(pend_i & mask_i)) == '0);

    // R8: the code is a multiple of four and the low field is zero.
    p_code_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vector_o[DATA_W-CODE_W +: 2] == 2'b00) && (vector_o[LOW_W-1:0] == '0));

endmodule

// File: rtl/eivc_bus_port.sv
// Module: multi-cycle register bus slave.
// In the first cycle of an access it latches the command and a snapshot of
// the addressed register. It acknowledges after WAIT_CYC further cycles and
// drives the frozen snapshot as read data. A write is issued as a one-cycle
// strobe on the acknowledge edge. Assumes the master holds sel until ack and
// drops it for at least one cycle afterwards.
module eivc_bus_port #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rd_mux_i,
    output logic [1:0]        rd_addr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o,
    output logic              wr_stb_o,
    output logic [1:0]        wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1) + 1;

    logic              active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              we_q;
    logic [1:0]        addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] hold_q;
    logic              start;

    assign start     = sel_i & ~active_q;
    assign ack_o     = active_q && (cnt_q == CNT_W'(WAIT_CYC));
    assign rd_addr_o = addr_i;

    // Track the access: open on start, count wait cycles, close on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (ack_o) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // Latch the command and freeze the read snapshot at access start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            hold_q  <= '0;
        end else if (start) begin
            we_q    <= we_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            hold_q  <= rd_mux_i;
        end
    end

    assign rdata_o   = hold_q;
    assign wr_stb_o  = ack_o & we_q;
    assign wr_addr_o = addr_q;
    assign wr_data_o = wdata_q;

    // R10: the acknowledge is a single-cycle pulse.
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R10: a write strobe only occurs together with an acknowledge.
    p_wr_in_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ack_o);

    // R9: the read snapshot stays constant while an access remains open.
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q)) |-> $stable(hold_q));

endmodule

// File: rtl/eivc_top.sv
// Module: top level of the edge-selectable interrupt vector controller.
// It ties together edge detection, pending latches, masked priority vector
// and the bus port. It holds the mode and mask registers and drives the
// single interrupt request. Assumes a 2-bit word address (see eivc_pkg).
module eivc_top
    import eivc_pkg::*;
#(
    parameter int unsigned LINES    = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pin_i,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              irq_o
);

    localparam int unsigned PAD_W = DATA_W - LINES;

    logic [LINES-1:0]  mode_q;
    logic [LINES-1:0]  mask_q;
    logic [LINES-1:0]  edges;
    logic [LINES-1:0]  pend;
    logic [LINES-1:0]  clr;
    logic [DATA_W-1:0] vector;
    logic              any_src;
    logic [DATA_W-1:0] rd_mux;
    logic [1:0]        rd_addr;
    logic              wr_stb;
    logic [1:0]        wr_addr;
    logic [DATA_W-1:0] wr_data;

    eivc_edge_bank #(.LINES(LINES)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .mode_i (mode_q),
        .edge_o (edges)
    );

    eivc_pend_bank #(.LINES(LINES)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edges),
        .clr_i  (clr),
        .pend_o (pend)
    );

    eivc_prio_vec #(.LINES(LINES), .DATA_W(DATA_W)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .mask_i   (mask_q),
        .vector_o (vector),
        .any_o    (any_src)
    );

    eivc_bus_port #(.DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .rd_mux_i  (rd_mux),
        .rd_addr_o (rd_addr),
        .rdata_o   (bus_rdata),
        .ack_o     (bus_ack),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    // Register writes for the mode and mask words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
        end else if (wr_stb) begin
            if (wr_addr == RSEL_MODE) mode_q <= wr_data[LINES-1:0];
            if (wr_addr == RSEL_MASK) mask_q <= wr_data[LINES-1:0];
        end
    end

    // Write-one-to-clear strobe toward the pending latches.
    always_comb begin
        clr = '0;
        if (wr_stb && (wr_addr == RSEL_PEND)) begin
            clr = wr_data[LINES-1:0];
        end
    end

    // Read multiplexer feeding the bus snapshot.
    always_comb begin
        unique case (rsel_e'(rd_addr))
            RSEL_MODE: rd_mux = {{PAD_W{1'b0}}, mode_q};
            RSEL_MASK: rd_mux = {{PAD_W{1'b0}}, mask_q};
            RSEL_PEND: rd_mux = {{PAD_W{1'b0}}, pend};
            RSEL_VEC:  rd_mux = vector;
            default:   rd_mux = '0;
        endcase
    end

    assign irq_o = any_src;

    // R11: the request agrees with a non-zero vector code.
    p_irq_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vector[DATA_W-1 -: CODE_W] != '0));

    // R6: with everything masked, no request is raised.
    p_mask_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

endmodule

// File: tb/eivc_top_bench.sv
// Bench: sweeps every line in both modes, many mask patterns against a full
// pending set, and the freeze, clear-collision and timing corners.
module eivc_top_bench;

    localparam int unsigned LINES = 16;
    localparam int unsigned WAIT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = 16'hFFFF;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    eivc_top #(.LINES(LINES), .DATA_W(32), .WAIT_CYC(WAIT)) u_eivc_top (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .bus_ack(ack), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus access; called at a negedge, returns at a negedge with sel low.
    task automatic xfer(input logic w, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        int waits = 0;
        sel = 1'b1; we = w; addr = a; wdata = d;
        do begin
            @(negedge clk);
            waits++;
        end while (!ack && waits < 20);
        check(waits == WAIT + 1, "R10 ack latency", waits, WAIT + 1);
        r = rdata;
        @(negedge clk);
        sel = 1'b0;
        check(ack == 1'b0, "R10 ack one cycle", {31'd0, ack}, 32'd0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] r);
        xfer(1'b0, a, 32'd0, r);
    endtask

    function automatic logic [31:0] exp_vec(input logic [15:0] hit);
        for (int i = 0; i < 16; i++) begin
            if (hit[i]) return 32'((i + 1) * 4) << 24;
        end
        return 32'd0;
    endfunction

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [15:0] lfsr;
        logic [15:0] m;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check(r == 0, "R1 register after reset", r, 0);
        end

        // R2/R3: each line in each mode, with all masked (R6).
        for (int n = 0; n < 16; n++) begin
            for (int md = 0; md < 2; md++) begin
                wr(2'd0, 32'(md) << n);
                pins[n] = 1'b0;
                settle();
                rd(2'd2, r);
                check(r == (32'd1 << n), md ? "R3 fall sets pending" : "R2 fall sets pending",
                      r, 32'd1 << n);
                check(irq == 1'b0, "R6 masked line no irq", {31'd0, irq}, 0);
                wr(2'd2, 32'hFFFF);
                pins[n] = 1'b1;
                settle();
                rd(2'd2, r);
                check(r == (md ? (32'd1 << n) : 32'd0),
                      md ? "R3 rise sets pending" : "R2 rise ignored",
                      r, md ? (32'd1 << n) : 32'd0);
                wr(2'd2, 32'hFFFF);
            end
        end

        // Build a full pending set with any-change mode.
        wr(2'd0, 32'hFFFF);
        pins = 16'h0000;
        settle();
        rd(2'd2, r);
        check(r == 32'hFFFF, "R3 all lines pending", r, 32'hFFFF);

        // R7/R8/R11: single-line masks.
        for (int n = 0; n < 16; n++) begin
            wr(2'd1, 32'd1 << n);
            rd(2'd3, r);
            check(r == exp_vec(16'd1 << n), "R8 vector word", r, exp_vec(16'd1 << n));
            check(r[31:24] == 8'((n + 1) * 4), "R8 byte offset", {24'd0, r[31:24]}, (n + 1) * 4);
            check(r[31:16] == 16'((n + 1) * 1024), "R8 halfword offset", {16'd0, r[31:16]},
                  (n + 1) * 1024);
            check(irq == 1'b1, "R11 irq with unmasked pending", {31'd0, irq}, 1);
        end
        // R7: masks whose lowest enabled line is k.
        for (int k = 0; k < 16; k++) begin
            m = 16'hFFFF << k;
            wr(2'd1, {16'd0, m});
            rd(2'd3, r);
            check(r == exp_vec(m), "R7 lowest line wins", r, exp_vec(m));
        end
        // R7: pseudo-random masks.
        lfsr = 16'hACE1;
        for (int t = 0; t < 40; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr(2'd1, {16'd0, lfsr});
            rd(2'd3, r);
            check(r == exp_vec(lfsr), "R7 random mask priority", r, exp_vec(lfsr));
            check(irq == (lfsr != 0), "R11 irq follows mask", {31'd0, irq}, {31'd0, lfsr != 0});
        end
        // R6/R8: everything masked.
        wr(2'd1, 32'd0);
        rd(2'd3, r);
        check(r == 0, "R8 empty vector is zero", r, 0);
        check(irq == 1'b0, "R6 all masked no irq", {31'd0, irq}, 0);

        // R4: partial clear and zero write.
        wr(2'd2, 32'h00FF);
        rd(2'd2, r);
        check(r == 32'hFF00, "R4 partial clear", r, 32'hFF00);
        wr(2'd2, 32'h0000);
        rd(2'd2, r);
        check(r == 32'hFF00, "R4 zero write keeps bits", r, 32'hFF00);
        wr(2'd2, 32'hFFFF);

        // R9: vector frozen across a read while line 2 becomes pending.
        wr(2'd1, 32'hFFFF);
        pins[10] = 1'b1;
        settle();
        rd(2'd3, r);
        check(r == exp_vec(16'h0400), "R9 setup vector", r, exp_vec(16'h0400));
        fork
            rd(2'd3, r);
            pins[2] = 1'b1;
        join
        check(r == exp_vec(16'h0400), "R9 frozen during read", r, exp_vec(16'h0400));
        rd(2'd3, r);
        check(r == exp_vec(16'h0404), "R9 new source after read", r, exp_vec(16'h0404));

        // R5: edge lands on the clear edge of the same bit.
        wr(2'd0, 32'd0);
        pins = 16'hFFFF;
        settle();
        wr(2'd2, 32'hFFFF);
        pins[5] = 1'b0;
        settle();
        pins[5] = 1'b1;
        settle();
        fork
            wr(2'd2, 32'h0020);
            begin
                @(posedge clk);
                @(negedge clk);
                pins[5] = 1'b0;
            end
        join
        rd(2'd2, r);
        check(r == 32'h0020, "R5 set wins over clear", r, 32'h0020);
        check(irq == 1'b1, "R5 irq kept", {31'd0, irq}, 1);
        wr(2'd2, 32'h0020);
        rd(2'd2, r);
        check(r == 0, "R4 clear without edge", r, 0);
        check(irq == 1'b0, "R11 irq drops", {31'd0, irq}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule